// File: doc/BRIEF.md
# ADC channel scan sequencer

This block is the digital controller that sits beside an eight-input analog-to-digital converter. Software programs a control/status register with a channel field, a scan-mode bit, a conversion-speed bit and a start bit. The block then drives the converter's channel-select lines and times each conversion window. At the end of a window it samples the converter's 10-bit data input into a result register for that channel, and it flags completion.

Single mode converts one channel once and then stops. Scan mode sweeps a group of channels in ascending order and wraps back to the start of the group until software stops it. Besides a software write, a conversion can be launched by the rising edge of an external trigger or of a timer compare-match pulse. That path works only when the enable bit in a separate trigger control register is set.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x40 and the trigger register (address 1) reads 0x7F. The block is idle with channel select 0. Control/status layout: bits [2:0] channel, bit 3 fast conversion, bit 4 scan mode, bit 5 start, bit 6 always reads 1, bit 7 done.
- R2: In single mode the channel field names one input (0 to 7). At the end of its window `adc_data` is stored as that channel's result, the start bit clears itself and the done bit is set.
- R3: A conversion window lasts 134 clock cycles with the fast bit at 0 and 70 cycles with it at 1. It is counted from the clock edge that sets the start bit up to and including the edge that stores the result.
- R4: In scan mode, channel bit 2 picks the group (0: inputs 0 to 3, 1: inputs 4 to 7). Channel bits [1:0] plus one give the number of group members converted, in ascending order from the first member. The sequence wraps and the start bit stays set.
- R5: The done bit is set at the end of every scan pass. Writing 0 to bit 7 of the control/status register clears it, and writing 1 leaves it unchanged.
- R6: While trigger register bit 7 is 1, a rising edge on `ext_trig` or `tmr_match` sets the start bit when it is clear. While bit 7 is 0, both inputs have no effect.
- R7: In the trigger register only bit 7 is writable, and bits [6:0] always read 1. Reset and the `stby` input return it to 0x7F.
- R8: While the start bit is 1, writes to the channel, scan and fast fields are ignored.
- R9: Writing 0 to the start bit during a conversion stops it at once. No result register changes and done is not set.
- R10: A trigger edge that arrives during a conversion does not restart or lengthen it. A trigger held high starts only one conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby | input | 1 | Standby: returns the trigger register to 0x7F |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 control/status, 1 trigger |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ext_trig | input | 1 | External trigger, rising-edge sensitive |
| tmr_match | input | 1 | Timer compare-match trigger, rising-edge sensitive |
| adc_data | input | 10 | Converter output, sampled at the end of a window |
| res_sel | input | 3 | Result register select |
| res_data | output | 10 | Result of the selected channel |
| adc_ch | output | 3 | Channel select to the analog multiplexer |
| conv_busy | output | 1 | High while the start bit is set |
| conv_strobe | output | 1 | High in the last cycle of a window that stores a result |
| done_flag | output | 1 | Done bit |

## Verification
Some properties are checked on every cycle. The configuration stays frozen while the start bit is set. The window counter stays inside the selected length. Scan channels stay inside the programmed group. A single conversion clears its own start bit, while a scan keeps it set. An abort never coincides with a result write, and standby clears the trigger enable. Other behaviour can only be shown by the bench's scenarios. These are the exact window lengths, the wrap order of each scan group, done clearing, results left untouched after an abort, and a held or repeated trigger not producing extra conversions.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W   = 3;
  localparam int NUM_CH = 1 << CH_W;
  localparam logic ADDR_CSR  = 1'b0;
  localparam logic ADDR_TRIG = 1'b1;

  typedef struct packed {
    logic            scan;
    logic            fast;
    logic [CH_W-1:0] chan;
  } adc_cfg_t;

  function automatic int unsigned conv_len(input logic fast,
                                           input int unsigned slow_len,
                                           input int unsigned fast_len);
    return fast ? fast_len : slow_len;
  endfunction

  function automatic logic [CH_W-2:0] last_idx(input adc_cfg_t cfg);
    return cfg.scan ? cfg.chan[CH_W-2:0] : '0;
  endfunction

  function automatic logic [CH_W-1:0] phys_ch(input adc_cfg_t cfg,
                                              input logic [CH_W-2:0] idx);
    return cfg.scan ? {cfg.chan[CH_W-1], idx} : cfg.chan;
  endfunction
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  output logic               rise
);
  logic [NUM_SRC-1:0] rise_vec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= src[i];
    end
    assign rise_vec[i] = src[i] & ~prev_q;
  end

  assign rise = |rise_vec;
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stby,
  input  logic     wr_en,
  input  logic     addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic     trig_rise,
  input  logic     conv_end,
  input  logic     pass_end,
  output logic     start_q,
  output logic     done_q,
  output adc_cfg_t cfg,
  output logic     abort,
  output logic     trig_start
);
  logic trig_en_q;
  logic wr_csr, wr_trig, sw_start, single_fin, set_done;
  wire  unused_wbit = &{1'b0, wdata[6]};

  assign wr_csr     = wr_en && (addr == ADDR_CSR);
  assign wr_trig    = wr_en && (addr == ADDR_TRIG);
  assign abort      = wr_csr & start_q & ~wdata[5];
  assign sw_start   = wr_csr & ~start_q & wdata[5];
  assign trig_start = trig_en_q & trig_rise & ~start_q & ~wr_csr;
  assign set_done   = conv_end & pass_end & ~abort;
  assign single_fin = set_done & ~cfg.scan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        start_q <= 1'b0;
    else if (abort)                    start_q <= 1'b0;
    else if (sw_start || trig_start)   start_q <= 1'b1;
    else if (single_fin)               start_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cfg <= '0;
    else if (wr_csr && !start_q)  cfg <= '{scan: wdata[4], fast: wdata[3], chan: wdata[2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   done_q <= 1'b0;
    else if (set_done)            done_q <= 1'b1;
    else if (wr_csr && !wdata[7]) done_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trig_en_q <= 1'b0;
    else if (stby)     trig_en_q <= 1'b0;
    else if (wr_trig)  trig_en_q <= wdata[7];
  end

  always_comb begin
    if (addr == ADDR_CSR) rdata = {done_q, 1'b1, start_q, cfg.scan, cfg.fast, cfg.chan};
    else                  rdata = {trig_en_q, 7'h7F};
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_q && $past(start_q) |-> $stable(cfg)); // R8
  AST_STBY_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> (rdata[7] == 1'b0 || addr == ADDR_CSR) && !trig_en_q); // R7
  AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_start |=> start_q); // R6
  AST_SINGLE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end && !cfg.scan && !abort |=> !start_q && done_q); // R2
  AST_SCAN_KEEPS_START: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end && cfg.scan && !abort |=> start_q); // R4
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int SLOW_LEN = 134,
  parameter int FAST_LEN = 70
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  adc_cfg_t        cfg,
  input  logic            abort,
  output logic [CH_W-1:0] ch_sel,
  output logic            conv_end,
  output logic            pass_end,
  output logic            res_we
);
  localparam int MAX_LEN = (SLOW_LEN > FAST_LEN) ? SLOW_LEN : FAST_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt_q, len_m1;
  logic [CH_W-2:0]  idx_q;

  assign len_m1   = CNT_W'(conv_len(cfg.fast, SLOW_LEN, FAST_LEN) - 1);
  assign conv_end = busy && (cnt_q == len_m1);
  assign pass_end = (idx_q == last_idx(cfg));
  assign res_we   = conv_end & ~abort;
  assign ch_sel   = phys_ch(cfg, idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (!busy) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (conv_end) begin
      cnt_q <= '0;
      idx_q <= pass_end ? '0 : idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt_q <= len_m1); // R3
  AST_CH_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg.scan |-> ch_sel[CH_W-1] == cfg.chan[CH_W-1] &&
                         ch_sel[CH_W-2:0] <= cfg.chan[CH_W-2:0]); // R4
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              abort,
  input  logic [CH_W-1:0]   wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CH_W-1:0]   rsel,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] res_q [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             res_q[i] <= '0;
      else if (we && wsel == CH_W'(i))        res_q[i] <= wdata;
    end
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && wsel == CH_W'(i)) |=> $stable(res_q[i])); // R9
  end

  assign rdata = res_q[rsel];

  AST_NO_RESULT_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !we); // R9
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int SLOW_LEN = 134,
  parameter int FAST_LEN = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ext_trig,
  input  logic              tmr_match,
  input  logic [DATA_W-1:0] adc_data,
  input  logic [CH_W-1:0]   res_sel,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   adc_ch,
  output logic              conv_busy,
  output logic              conv_strobe,
  output logic              done_flag
);
  adc_cfg_t cfg;
  logic start_q, abort, trig_start, trig_rise;
  logic conv_end, pass_end, res_we;

  adc_seq_trig #(.NUM_SRC(2)) u_trig (
    .clk(clk), .rst_n(rst_n), .src({tmr_match, ext_trig}), .rise(trig_rise)
  );

  adc_seq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .stby(stby),
    .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .trig_rise(trig_rise), .conv_end(conv_end), .pass_end(pass_end),
    .start_q(start_q), .done_q(done_flag), .cfg(cfg),
    .abort(abort), .trig_start(trig_start)
  );

  adc_seq_timer #(.SLOW_LEN(SLOW_LEN), .FAST_LEN(FAST_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .busy(start_q), .cfg(cfg), .abort(abort),
    .ch_sel(adc_ch), .conv_end(conv_end), .pass_end(pass_end), .res_we(res_we)
  );

  adc_seq_results #(.DATA_W(DATA_W)) u_res (
    .clk(clk), .rst_n(rst_n), .we(res_we), .abort(abort),
    .wsel(adc_ch), .wdata(adc_data), .rsel(res_sel), .rdata(res_data)
  );

  assign conv_busy   = start_q;
  assign conv_strobe = res_we;

  AST_TRIG_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy && !conv_strobe && !abort |=> conv_busy); // R10
endmodule

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0, stby = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic ext_trig = 1'b0, tmr_match = 1'b0;
  logic [9:0] adc_data = '0, res_data;
  logic [2:0] res_sel = '0, adc_ch;
  logic conv_busy, conv_strobe, done_flag;
  int checks = 0, fails = 0, strobe_cnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_scan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .stby(stby), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_trig(ext_trig),
    .tmr_match(tmr_match), .adc_data(adc_data), .res_sel(res_sel),
    .res_data(res_data), .adc_ch(adc_ch), .conv_busy(conv_busy),
    .conv_strobe(conv_strobe), .done_flag(done_flag)
  );

  always @(negedge clk) if (conv_strobe) strobe_cnt++;

  function automatic int exp_len(input bit fast);
    return fast ? 70 : 134;
  endfunction

  function automatic logic [2:0] exp_scan_ch(input logic [2:0] chan, input int k);
    int members = int'(chan[1:0]) + 1;
    return {chan[2], 2'(k % members)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [7:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic read_res(input logic [2:0] ch, output logic [9:0] v);
    res_sel = ch; #0.5; v = res_data;
  endtask

  task automatic wait_strobe(output int n);
    n = 0;
    while (!conv_strobe && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic single_conv(input logic [2:0] ch, input bit fast, input string req);
    int n; logic [9:0] d, r; logic [7:0] c;
    d = 10'($urandom);
    adc_data = d;
    reg_write(1'b0, {2'b00, 1'b1, 1'b0, fast, ch});
    wait_strobe(n);
    check(n + 1 == exp_len(fast), "R3", n + 1, exp_len(fast));
    check(adc_ch == ch, req, adc_ch, ch);
    @(negedge clk);
    adc_data = ~d;
    read_res(ch, r);
    check(r == d, "R2", r, d);
    reg_read(1'b0, c);
    check(c[7:5] == 3'b110 && !conv_busy, "R2", c, {3'b110, 5'b0});
  endtask

  initial begin
    int n, sc0; logic [7:0] c; logic [9:0] d, r, keep; logic [2:0] ch;
    void'($urandom(32'd7411));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(1'b0, c); check(c == 8'h40, "R1", c, 8'h40);
    reg_read(1'b1, c); check(c == 8'h7F, "R1", c, 8'h7F);
    check(!conv_busy && adc_ch == 3'd0 && !done_flag, "R1", {conv_busy, adc_ch}, 0);

    // R2 / R3 directed
    single_conv(3'd3, 1'b0, "R2");
    single_conv(3'd6, 1'b1, "R2");
    // R5 done clear
    reg_write(1'b0, 8'h00);
    check(!done_flag, "R5", done_flag, 0);

    // random single conversions
    for (int i = 0; i < 12; i++) single_conv(3'($urandom), 1'($urandom), "R2");

    // R4 scan group 1, two members, fast
    reg_write(1'b0, 8'h3D);
    for (int k = 0; k < 6; k++) begin
      d = 10'($urandom); adc_data = d;
      wait_strobe(n);
      if (k == 0) check(n + 1 == 70, "R3", n + 1, 70);
      check(adc_ch == exp_scan_ch(3'd5, k), "R4", adc_ch, exp_scan_ch(3'd5, k));
      @(negedge clk);
      read_res(adc_ch == 3'd4 ? 3'd5 : 3'd4, r);
      read_res(exp_scan_ch(3'd5, k), r);
      check(r == d, "R4", r, d);
      check(conv_busy, "R4", conv_busy, 1);
      if (k == 1) check(done_flag, "R5", done_flag, 1);
      if (k == 2) begin
        // R8 config write ignored while running, also clears done (R5)
        reg_write(1'b0, 8'h20);
        reg_read(1'b0, c);
        check(c[5:0] == 6'b111101, "R8", c[5:0], 6'b111101);
        check(!done_flag, "R5", done_flag, 0);
      end
    end
    // R9 abort
    repeat (10) @(negedge clk);
    read_res(adc_ch, keep); ch = adc_ch;
    adc_data = ~keep;
    sc0 = strobe_cnt;
    reg_write(1'b0, 8'h00);
    check(!conv_busy, "R9", conv_busy, 0);
    repeat (200) @(negedge clk);
    read_res(ch, r);
    check(r == keep && strobe_cnt == sc0, "R9", r, keep);
    check(!done_flag, "R9", done_flag, 0);

    // R4 group 0 all four members
    reg_write(1'b0, 8'h3B);
    for (int k = 0; k < 5; k++) begin
      wait_strobe(n);
      check(adc_ch == exp_scan_ch(3'd3, k), "R4", adc_ch, exp_scan_ch(3'd3, k));
      @(negedge clk);
      if (k == 3) check(done_flag, "R5", done_flag, 1);
    end
    reg_write(1'b0, 8'h00);
    // R4 single-member scan
    reg_write(1'b0, 8'h3C);
    for (int k = 0; k < 3; k++) begin
      wait_strobe(n);
      check(adc_ch == 3'd4 && conv_busy, "R4", adc_ch, 4);
      @(negedge clk);
    end
    reg_write(1'b0, 8'h00);

    // R6 triggers disabled
    reg_write(1'b0, 8'h0A);
    ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    tmr_match = 1'b1; @(negedge clk); tmr_match = 1'b0;
    repeat (3) @(negedge clk);
    check(!conv_busy, "R6", conv_busy, 0);
    // R7 only bit 7 writable
    reg_write(1'b1, 8'h80);
    reg_read(1'b1, c); check(c == 8'hFF, "R7", c, 8'hFF);
    // R6 timer trigger, R10 trigger during conversion ignored
    tmr_match = 1'b1; @(negedge clk); tmr_match = 1'b0;
    check(conv_busy, "R6", conv_busy, 1);
    ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    wait_strobe(n);
    check(n + 2 == 70, "R10", n + 2, 70);
    check(adc_ch == 3'd2, "R6", adc_ch, 2);
    @(negedge clk);
    check(!conv_busy, "R6", conv_busy, 0);
    // R10 held trigger starts one conversion only
    sc0 = strobe_cnt;
    ext_trig = 1'b1;
    repeat (200) @(negedge clk);
    check(strobe_cnt == sc0 + 1 && !conv_busy, "R10", strobe_cnt - sc0, 1);
    ext_trig = 1'b0;

    // R7 write of zeros, then standby
    reg_write(1'b1, 8'h00);
    reg_read(1'b1, c); check(c == 8'h7F, "R7", c, 8'h7F);
    reg_write(1'b1, 8'hFF);
    stby = 1'b1; @(negedge clk); stby = 1'b0;
    reg_read(1'b1, c); check(c == 8'h7F, "R7", c, 8'h7F);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule